// File: doc/BRIEF.md
# Event Counter with Snapshot Handshake

This block counts single-cycle event strobes in a running counter. The counter saturates at all-ones. On request, the block copies the running count into a holding register that a reader can sample. The copy is started by a rising edge on an update-request input. A short sequence then runs: the status output drops, the count is copied, the running counter restarts, and the zero-count flag pulses low. At the end the status output rises again to mark the holding register as valid.

The copy and the restart happen on the same clock edge. An event seen on that edge starts the new interval, so no event is lost or counted twice. A sticky overflow flag records any event that arrives while the counter is saturated. A read strobe clears the flag.

The reset `rst_n` is asynchronous and active low, and its release is expected to be synchronous to `clk`. The counter width is a parameter, `CNT_W`, with a default of 16.

Top module: `perf_snap`

## Requirements
- R1: While `rst_n` is low, and after its release until the first event, `snap_valid_o`=0, `snap_count_o`=0, `ovf_o`=0 and `zero_o`=1.
- R2: Each clock edge that samples `event_i` high adds one to the running count, as long as the counter is below all-ones.
- R3: The running count holds at all-ones. An event sampled while the count is all-ones leaves the count unchanged and sets `ovf_o` after that edge.
- R4: A snapshot starts only at an edge where `upd_req_i` is 1 and was 0 at the previous edge. Holding `upd_req_i` high has no further effect.
- R5: Suppose a snapshot starts at edge k. Then `snap_valid_o` is 0 after edge k and after edge k+1, and it returns to 1 after edge k+2.
- R6: At edge k+1, `snap_count_o` takes the number of events sampled on edges up to and including edge k. The running count restarts at 1 if `event_i` is high at edge k+1, and at 0 otherwise.
- R7: `zero_o` is 0 for exactly the cycle after edge k+1, whatever the running count is.
- R8: At all other times `zero_o` is 1 exactly when the running count is 0.
- R9: A rising edge of `upd_req_i` that falls on edge k+1 or edge k+2 of a snapshot in progress is ignored.
- R10: A high `ovf_rd_i` clears `ovf_o` after the edge. If a saturating event arrives on the same edge, setting wins. Once cleared, `ovf_o` sets again only on a new saturating event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_i | input | 1 | Event strobe, one count per cycle high |
| upd_req_i | input | 1 | Snapshot request; the rising edge is acted on |
| ovf_rd_i | input | 1 | Read strobe that clears the overflow flag |
| snap_valid_o | output | 1 | Holding register valid |
| snap_count_o | output | CNT_W | Holding register value |
| zero_o | output | 1 | Running count is zero (forced low during the update) |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Assertions check the following on every cycle:
- the counter's single-step and saturation behaviour;
- that the overflow flag stays set until read;
- the three-state order of the update, including that a new request is ignored in its final state;
- that the holding register equals the count from the cycle before the load, and the restart at 1.

The bench's scenarios are needed for the following:
- the absolute values captured across several intervals;
- the exact timing of the zero-flag pulse when the count is already zero;
- a steady-high request having no effect;
- set winning over read on the same edge;
- the state seen during an asynchronous reset in the middle of a run.

// File: rtl/perf_snap_pkg.sv
package perf_snap_pkg;
  typedef enum logic [1:0] {
    SN_IDLE   = 2'd0,
    SN_LOAD   = 2'd1,
    SN_ZPULSE = 2'd2
  } snap_state_e;
endpackage

// File: rtl/psnap_edge.sv
// Rising-edge detector for the update request.
module psnap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic rise_o
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_i;
  end

  assign rise_o = req_i & ~req_q;

  // R4: a detected edge cannot repeat on the next cycle
  p_single_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/psnap_seq.sv
// Update sequencer: idle -> load -> zero pulse -> idle, with the valid status.
module psnap_seq
  import perf_snap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  output logic load_o,
  output logic zpulse_o,
  output logic valid_o
);
  snap_state_e state_q, state_d;
  logic        valid_q, valid_d;

  always_comb begin
    state_d = state_q;
    valid_d = valid_q;
    case (state_q)
      SN_IDLE: begin
        if (rise_i) begin
          state_d = SN_LOAD;
          valid_d = 1'b0;
        end
      end
      SN_LOAD:   state_d = SN_ZPULSE;
      SN_ZPULSE: begin
        state_d = SN_IDLE;
        valid_d = 1'b1;
      end
      default:   state_d = SN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SN_IDLE;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
    end
  end

  assign load_o   = (state_q == SN_LOAD);
  assign zpulse_o = (state_q == SN_ZPULSE);
  assign valid_o  = valid_q;

  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SN_IDLE && rise_i) |=> (!valid_o && load_o));
  p_hold_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (zpulse_o && !valid_o));
  p_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zpulse_o |=> (valid_o && state_q == SN_IDLE));
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (zpulse_o && rise_i) |=> !load_o);
endmodule

// File: rtl/psnap_count.sv
// Saturating event counter, holding register and sticky overflow flag.
module psnap_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_i,
  input  logic             load_i,
  input  logic             rd_clr_i,
  output logic [CNT_W-1:0] hold_o,
  output logic             cnt_zero_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d, hold_q;
  logic             ovf_q, ovf_d, sat_ev;

  assign sat_ev = ev_i && !load_i && (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                          cnt_d = ev_i ? CNT_ONE : '0;
    else if (ev_i && cnt_q != CNT_MAX)   cnt_d = cnt_q + CNT_ONE;
  end

  always_comb begin
    ovf_d = ovf_q;
    if (sat_ev)        ovf_d = 1'b1;
    else if (rd_clr_i) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (load_i) hold_q <= cnt_q;
  end

  assign hold_o     = hold_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign ovf_o      = ovf_q;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && !load_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE));
  p_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sat_ev |=> (cnt_q == CNT_MAX && ovf_q));
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (hold_q == $past(cnt_q)));
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && ev_i) |=> (cnt_q == CNT_ONE));
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !rd_clr_i) |=> ovf_q);
endmodule

// File: rtl/perf_snap.sv
module perf_snap #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_i,
  input  logic             upd_req_i,
  input  logic             ovf_rd_i,
  output logic             snap_valid_o,
  output logic [CNT_W-1:0] snap_count_o,
  output logic             zero_o,
  output logic             ovf_o
);
  logic rise, load, zpulse, cnt_zero;

  psnap_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (upd_req_i),
    .rise_o (rise)
  );

  psnap_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (rise),
    .load_o   (load),
    .zpulse_o (zpulse),
    .valid_o  (snap_valid_o)
  );

  psnap_count #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_i       (event_i),
    .load_i     (load),
    .rd_clr_i   (ovf_rd_i),
    .hold_o     (snap_count_o),
    .cnt_zero_o (cnt_zero),
    .ovf_o      (ovf_o)
  );

  assign zero_o = cnt_zero & ~zpulse;

  // R7: right after the load edge, the flag is low
  p_zero_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !zero_o);
endmodule

// File: tb/perf_snap_test.sv
`timescale 1ns/1ps
module perf_snap_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         event_i, upd_req_i, ovf_rd_i;
  logic         snap_valid_o, zero_o, ovf_o;
  logic [W-1:0] snap_count_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  perf_snap #(.CNT_W(W)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .event_i      (event_i),
    .upd_req_i    (upd_req_i),
    .ovf_rd_i     (ovf_rd_i),
    .snap_valid_o (snap_valid_o),
    .snap_count_o (snap_count_o),
    .zero_o       (zero_o),
    .ovf_o        (ovf_o)
  );

  // {ev, req, rd, exp_valid, exp_zero, exp_ovf, exp_hold}
  localparam logic [5+W:0] VEC [19] = '{
    {3'b100, 3'b000, 8'd0},  // 0  R2 count 1
    {3'b100, 3'b000, 8'd0},  // 1  count 2
    {3'b100, 3'b000, 8'd0},  // 2  count 3
    {3'b010, 3'b000, 8'd0},  // 3  rise: R5 valid drops
    {3'b010, 3'b000, 8'd3},  // 4  R6 load 3, R7 zero forced low
    {3'b010, 3'b110, 8'd3},  // 5  R5 valid back, R8 zero
    {3'b010, 3'b110, 8'd3},  // 6  R4 steady high, nothing
    {3'b100, 3'b100, 8'd3},  // 7  R8 count 1, zero low
    {3'b110, 3'b000, 8'd3},  // 8  rise with event: old interval gets 2
    {3'b110, 3'b000, 8'd2},  // 9  R6 load 2, event restarts count at 1
    {3'b000, 3'b100, 8'd2},  // 10 count 1, zero low
    {3'b010, 3'b000, 8'd2},  // 11 rise
    {3'b000, 3'b000, 8'd1},  // 12 load 1
    {3'b010, 3'b110, 8'd1},  // 13 R9 rise in final state ignored
    {3'b010, 3'b110, 8'd1},  // 14 still idle
    {3'b000, 3'b110, 8'd1},  // 15
    {3'b010, 3'b010, 8'd1},  // 16 rise with count zero
    {3'b010, 3'b000, 8'd0},  // 17 R7 zero low even though count is 0
    {3'b010, 3'b110, 8'd0}   // 18 valid, hold 0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic ev, input logic req, input logic rd);
    event_i   = ev;
    upd_req_i = req;
    ovf_rd_i  = rd;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; event_i = 1'b0; upd_req_i = 1'b0; ovf_rd_i = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 valid", snap_valid_o, 0);
    chk("R1 hold", snap_count_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 zero", zero_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 zero after release", zero_o, 1);

    for (int i = 0; i < 19; i++) begin
      cyc(VEC[i][W+5], VEC[i][W+4], VEC[i][W+3]);
      chk($sformatf("vec %0d valid R5", i), snap_valid_o, VEC[i][W+2]);
      chk($sformatf("vec %0d zero R7 R8", i), zero_o, VEC[i][W+1]);
      chk($sformatf("vec %0d ovf", i), ovf_o, VEC[i][W]);
      chk($sformatf("vec %0d hold R2 R4 R6 R9", i), snap_count_o, VEC[i][W-1:0]);
    end

    // R3 saturation
    repeat (255) cyc(1'b1, 1'b0, 1'b0);
    chk("R3 no ovf at max", ovf_o, 0);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R3 ovf set", ovf_o, 1);
    // R10 set wins over read
    cyc(1'b1, 1'b0, 1'b1);
    chk("R10 set dominates", ovf_o, 1);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R10 cleared by read", ovf_o, 0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R10 stays clear", ovf_o, 0);
    cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R3 hold saturated", snap_count_o, 255);
    chk("R3 valid", snap_valid_o, 1);
    chk("R8 zero after clear", zero_o, 1);
    // R10 rearm on new saturation
    repeat (256) cyc(1'b1, 1'b0, 1'b0);
    chk("R10 rearmed", ovf_o, 1);

    // R1 asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 mid valid", snap_valid_o, 0);
    chk("R1 mid hold", snap_count_o, 0);
    chk("R1 mid ovf", ovf_o, 0);
    chk("R1 mid zero", zero_o, 1);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0);
    chk("R1 after release", snap_valid_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule